// File: doc/BRIEF.md
# DMA Channel Bus-Mode Sequencer

This block sequences the bus cycles of one DMA channel on a shared system bus. Software loads a transfer description with a one-cycle `start` pulse. The description holds a bus mode, a unit size, a unit count, a source address and a destination address. The channel then waits for its external request line, which is active low and sensed by level. While the line is low the channel asks the bus arbiter for mastership and moves units once the grant arrives.

The mode decides how long the channel holds the bus:
- **Cycle-steal mode:** the channel gives the bus back after every unit and asks for it again for the next one.
- **Burst mode:** the channel keeps the bus and runs the units back to back until the count is used up. If the request line has gone high by the end of a unit, the channel releases the bus at that boundary and resumes later.

Each unit is carried in one of two ways:
- **Dual-address:** a read cycle at the source followed by a write cycle at the destination.
- **Single-address:** a single read cycle at the source, with the acknowledge strobe telling the external device to take part in the cycle.

Every bus cycle takes one clock while the channel is granted.

Top module: `dma_busmode_seq`

## Requirements
- R1: After reset, `bus_req`, `bus_rd`, `bus_wr`, `dack` and `done` are all low.
- R2: In cycle-steal mode (`cfg_burst`=0) the channel moves exactly one unit per bus tenure. `bus_req` falls in the cycle after each unit's last bus cycle, so the number of `bus_req` releases equals the number of units.
- R3: In burst mode (`cfg_burst`=1) with `dreq_n` held low, every unit runs back to back under a single tenure, and `bus_req` falls only once, after the last unit.
- R4: In burst mode, if `dreq_n` is high when a unit finishes, `bus_req` falls in the next cycle even though units remain. The remaining units resume under a new tenure once `dreq_n` is low again, and the total unit count is unchanged.
- R5: In dual-address mode (`cfg_dual`=1) each unit is a read cycle at the source address, followed in the very next cycle by a write cycle at the destination address.
- R6: In single-address mode (`cfg_dual`=0) each unit is one read cycle at the source address, and `bus_wr` never rises.
- R7: Exactly `cfg_count` units are moved. `done` is high for one cycle only, in the cycle after the last bus cycle. With `cfg_count`=0, `done` pulses within three cycles of `start` and no bus cycle occurs.
- R8: After each unit the source and destination addresses advance by the unit size, where `cfg_size` 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.
- R9: `bus_req` rises only after `dreq_n` has been sampled low while the channel waits between units. `bus_rd` and `bus_wr` stay low until `bus_gnt` is high.
- R10: `dack` is high for exactly one cycle per unit, and that cycle is the unit's first bus cycle (the read cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse; loads the configuration when the channel is idle |
| cfg_burst | input | 1 | 1 = burst mode, 0 = cycle-steal mode |
| cfg_dual | input | 1 | 1 = dual-address, 0 = single-address |
| cfg_size | input | 2 | Unit size: 0 byte, 1 word, 2/3 longword |
| cfg_count | input | CNT_W | Number of units to move |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| dreq_n | input | 1 | External transfer request, active low, level sensed |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_addr | output | AW | Address of the current bus cycle, zero when no cycle runs |
| bus_size | output | 2 | Latched unit size of the current transfer |
| dack | output | 1 | Per-unit acknowledge to the requesting device |
| done | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
The hardest situation to reach is the burst-mode early release. The request line has to go high during a unit and still be high at that unit's boundary, with units left to move. The stimulus waits at falling clock edges until it has seen the second `dack` of a dual-address burst, then raises `dreq_n` while that unit's write cycle is still ahead. The bench then checks several things:
- Exactly two units have moved.
- `bus_req` has dropped.
- After `dreq_n` returns low, the remaining units arrive under a second tenure, with addresses continuing from where they stopped.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ARMED = 3'd1,
    S_WAITG = 3'd2,
    S_RD    = 3'd3,
    S_WR    = 3'd4
  } seq_state_t;

  // Byte increment for a unit size code: 0 -> 1, 1 -> 2, 2/3 -> 4.
  function automatic logic [2:0] unit_step(input logic [1:0] size);
    case (size)
      2'd0:    unit_step = 3'd1;
      2'd1:    unit_step = 3'd2;
      default: unit_step = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_unit_counter.sv
module dma_unit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_last,
  output logic             is_zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (dec)    cnt_q <= cnt_q - 1'b1;
  end

  assign is_last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
  assign is_zero = (cnt_q == '0);

  // R7: one decrement per finished unit
  p_count_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R7: no unit is finished once the count is used up
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !is_zero);
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step import dma_seq_pkg::*; #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic [1:0]    size,
  input  logic          adv,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] step;

  assign step = AW'(unit_step(size));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (load)  addr_q <= load_val;
    else if (adv)   addr_q <= addr_q + step;
  end

  assign addr = addr_q;

  // R8: address advances by exactly the unit size
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (addr_q == $past(addr_q) + $past(step)));
endmodule

// File: rtl/dma_bus_ctrl.sv
module dma_bus_ctrl import dma_seq_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cfg_burst,
  input  logic cfg_dual,
  input  logic cnt_last,
  input  logic cnt_zero,
  input  logic dreq_n,
  input  logic bus_gnt,
  output logic load,
  output logic unit_done,
  output logic wr_phase,
  output logic bus_req,
  output logic bus_rd,
  output logic bus_wr,
  output logic dack,
  output logic done
);
  seq_state_t st_q, st_d;
  logic       burst_q, dual_q, done_q;
  logic       set_done;
  logic       keep_bus;

  assign unit_done = ((st_q == S_RD) && !dual_q) || (st_q == S_WR);
  assign keep_bus  = burst_q && !dreq_n;
  assign set_done  = ((st_q == S_ARMED) && cnt_zero) || (unit_done && cnt_last);

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    case (st_q)
      S_IDLE:  if (start) begin
                 load = 1'b1;
                 st_d = S_ARMED;
               end
      S_ARMED: if (cnt_zero)     st_d = S_IDLE;
               else if (!dreq_n) st_d = S_WAITG;
      S_WAITG: if (bus_gnt)      st_d = S_RD;
      S_RD, S_WR: begin
        if ((st_q == S_RD) && dual_q) st_d = S_WR;
        else if (cnt_last)            st_d = S_IDLE;
        else if (keep_bus)            st_d = S_RD;
        else                          st_d = S_ARMED;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      burst_q <= 1'b0;
      dual_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= set_done;
      if (load) begin
        burst_q <= cfg_burst;
        dual_q  <= cfg_dual;
      end
    end
  end

  assign bus_req  = (st_q == S_WAITG) || (st_q == S_RD) || (st_q == S_WR);
  assign bus_rd   = (st_q == S_RD);
  assign bus_wr   = (st_q == S_WR);
  assign wr_phase = (st_q == S_WR);
  assign dack     = (st_q == S_RD);
  assign done     = done_q;

  // R9: no strobe without a grant
  p_strobe_needs_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_gnt);

  // R9: a request is raised only after the request line was seen low
  p_req_after_dreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(!dreq_n));

  // R2: cycle-steal releases after every unit
  p_cs_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !burst_q) |=> !bus_req);

  // R3: burst continues straight into the next unit
  p_burst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && burst_q && !cnt_last && !dreq_n) |=> (bus_rd && bus_req));

  // R4: burst gives the bus up at a unit boundary when the request line is high
  p_burst_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && burst_q && dreq_n) |=> !bus_req);

  // R5: dual-address read is followed by a write
  p_dual_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && dual_q) |=> bus_wr);

  // R6: single-address never writes
  p_single_no_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_q |-> !bus_wr);

  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: read and write strobes are never high together
  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));
endmodule

// File: rtl/dma_busmode_seq.sv
module dma_busmode_seq import dma_seq_pkg::*; #(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_burst,
  input  logic             cfg_dual,
  input  logic [1:0]       cfg_size,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [AW-1:0]    cfg_src,
  input  logic [AW-1:0]    cfg_dst,
  input  logic             dreq_n,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [AW-1:0]    bus_addr,
  output logic [1:0]       bus_size,
  output logic             dack,
  output logic             done
);
  localparam int N_PTR = 2;

  logic          load, unit_done, wr_phase;
  logic          cnt_last, cnt_zero;
  logic [1:0]    size_q;
  logic [AW-1:0] ptr_base [N_PTR];
  logic [AW-1:0] ptr_cur  [N_PTR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    size_q <= 2'd0;
    else if (load) size_q <= cfg_size;
  end

  assign ptr_base[0] = cfg_src;
  assign ptr_base[1] = cfg_dst;

  dma_bus_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_burst (cfg_burst),
    .cfg_dual  (cfg_dual),
    .cnt_last  (cnt_last),
    .cnt_zero  (cnt_zero),
    .dreq_n    (dreq_n),
    .bus_gnt   (bus_gnt),
    .load      (load),
    .unit_done (unit_done),
    .wr_phase  (wr_phase),
    .bus_req   (bus_req),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .dack      (dack),
    .done      (done)
  );

  dma_unit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (cfg_count),
    .dec      (unit_done),
    .is_last  (cnt_last),
    .is_zero  (cnt_zero)
  );

  for (genvar gi = 0; gi < N_PTR; gi++) begin : g_ptr
    dma_addr_step #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (ptr_base[gi]),
      .size     (size_q),
      .adv      (unit_done),
      .addr     (ptr_cur[gi])
    );
  end

  always_comb begin
    if (wr_phase)    bus_addr = ptr_cur[1];
    else if (bus_rd) bus_addr = ptr_cur[0];
    else             bus_addr = '0;
  end

  assign bus_size = size_q;

  // R10: acknowledge only in a read cycle, once per unit
  p_ack_in_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (bus_rd && !wr_phase));

  // R9: no address is driven outside a bus cycle
  p_addr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |-> (bus_addr == '0));
endmodule

// File: tb/dma_busmode_seq_test.sv
`timescale 1ns/1ps
module dma_busmode_seq_test;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, cfg_burst = 1'b0, cfg_dual = 1'b0;
  logic [1:0]    cfg_size = 2'd0;
  logic [CW-1:0] cfg_count = '0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic          dreq_n = 1'b1;
  logic          bus_gnt = 1'b0;
  logic          gnt_en = 1'b1;
  logic          bus_req, bus_rd, bus_wr, dack, done;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;

  int checks = 0, errors = 0;

  // Monitor state
  int          cyc = 0, n_rd = 0, n_wr = 0, n_ack = 0, n_rel = 0, n_done = 0;
  int          bad_ack = 0, bad_gnt = 0, last_s = 0, done_cyc = 0;
  logic        prev_req = 1'b0;
  logic [AW-1:0] rd_log [64];
  logic [AW-1:0] wr_log [64];

  always #2.5 clk = ~clk;

  dma_busmode_seq #(.AW(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_burst(cfg_burst),
    .cfg_dual(cfg_dual), .cfg_size(cfg_size), .cfg_count(cfg_count),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .dreq_n(dreq_n), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .dack(dack), .done(done)
  );

  // Arbiter model: grant one cycle after request
  always @(posedge clk) bus_gnt <= bus_req && gnt_en && rst_n;

  always @(negedge clk) begin
    cyc++;
    if (bus_rd) begin
      if (n_rd < 64) rd_log[n_rd] = bus_addr;
      n_rd++;
      last_s = cyc;
    end
    if (bus_wr) begin
      if (n_wr < 64) wr_log[n_wr] = bus_addr;
      n_wr++;
      last_s = cyc;
    end
    if (dack) begin
      n_ack++;
      if (!bus_rd) bad_ack++;
    end
    if ((bus_rd || bus_wr) && !bus_gnt) bad_gnt++;
    if (prev_req && !bus_req) n_rel++;
    prev_req = bus_req;
    if (done) begin
      n_done++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step_of(input logic [1:0] s);
    if (s == 2'd0) return 1;
    if (s == 2'd1) return 2;
    return 4;
  endfunction

  task automatic launch(input bit b, input bit d, input logic [1:0] s, input int cnt,
                        input logic [AW-1:0] src, input logic [AW-1:0] dst);
    @(posedge clk); #1;
    cfg_burst = b; cfg_dual = d; cfg_size = s; cfg_count = CW'(cnt);
    cfg_src = src; cfg_dst = dst;
    n_rd = 0; n_wr = 0; n_ack = 0; n_rel = 0; n_done = 0;
    bad_ack = 0; bad_gnt = 0;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k;
    k = 0;
    while (n_done == 0 && k < 400) begin
      @(negedge clk); k++;
    end
    @(negedge clk); @(negedge clk);
    chk(n_done == 1, req, n_done, 1);
  endtask

  task automatic chk_addrs(input string req, input int n, input logic [AW-1:0] base,
                           input int stp, input bit wr);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] got;
      logic [AW-1:0] exp;
      got = wr ? wr_log[i] : rd_log[i];
      exp = base + AW'(i * stp);
      chk(got == exp, req, got, exp);
    end
  endtask

  task automatic t_reset;
    chk(!bus_req && !bus_rd && !bus_wr, "R1 bus idle", {bus_req, bus_rd, bus_wr}, 0);
    chk(!dack && !done, "R1 dack/done", {dack, done}, 0);
  endtask

  task automatic t_cycle_steal_dual;
    dreq_n = 1'b0;
    launch(1'b0, 1'b1, 2'd2, 3, 32'h1000, 32'h2000);
    wait_done("R7 cs done");
    chk(n_rel == 3, "R2 releases per unit", n_rel, 3);
    chk(n_ack == 3 && bad_ack == 0, "R10 one dack per unit", n_ack, 3);
    chk(n_rd == 3 && n_wr == 3, "R5 rd/wr count", n_rd * 10 + n_wr, 33);
    chk_addrs("R5 R8 src long", 3, 32'h1000, 4, 1'b0);
    chk_addrs("R5 R8 dst long", 3, 32'h2000, 4, 1'b1);
    chk(done_cyc == last_s + 1, "R7 done timing", done_cyc - last_s, 1);
  endtask

  task automatic t_burst_dual;
    dreq_n = 1'b0;
    launch(1'b1, 1'b1, 2'd1, 4, 32'h300, 32'h500);
    wait_done("R7 burst done");
    chk(n_rel == 1, "R3 single tenure", n_rel, 1);
    chk(n_rd == 4 && n_wr == 4, "R7 unit count", n_rd, 4);
    chk_addrs("R8 src word", 4, 32'h300, 2, 1'b0);
    chk_addrs("R8 dst word", 4, 32'h500, 2, 1'b1);
    chk(done_cyc == last_s + 1, "R7 done timing burst", done_cyc - last_s, 1);
  endtask

  task automatic t_burst_single;
    dreq_n = 1'b0;
    launch(1'b1, 1'b0, 2'd0, 5, 32'h40, 32'h80);
    wait_done("R7 single done");
    chk(n_wr == 0, "R6 no write", n_wr, 0);
    chk(n_rd == 5 && n_ack == 5, "R6 R10 one cycle per unit", n_rd, 5);
    chk(n_rel == 1, "R3 single tenure single", n_rel, 1);
    chk_addrs("R6 R8 src byte", 5, 32'h40, 1, 1'b0);
    chk(bad_gnt == 0, "R9 grant held", bad_gnt, 0);
  endtask

  task automatic t_burst_early;
    int seen;
    int k;
    dreq_n = 1'b0;
    launch(1'b1, 1'b1, 2'd0, 6, 32'h10, 32'h90);
    seen = 0; k = 0;
    while (seen < 2 && k < 200) begin
      @(negedge clk); k++;
      if (dack) seen++;
    end
    dreq_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(n_ack == 2, "R4 stopped after boundary", n_ack, 2);
    chk(!bus_req && n_rel == 1, "R4 bus released", {bus_req, 8'(n_rel)}, 1);
    chk(n_done == 0, "R4 not done early", n_done, 0);
    @(posedge clk); #1; dreq_n = 1'b0;
    wait_done("R4 resumed done");
    chk(n_rd == 6 && n_wr == 6, "R4 total units", n_rd, 6);
    chk(n_rel == 2, "R4 two tenures", n_rel, 2);
    chk_addrs("R4 R8 src continues", 6, 32'h10, 1, 1'b0);
    chk_addrs("R4 R8 dst continues", 6, 32'h90, 1, 1'b1);
  endtask

  task automatic t_zero_count;
    int k;
    dreq_n = 1'b0;
    launch(1'b0, 1'b1, 2'd0, 0, 32'h0, 32'h0);
    k = 0;
    while (n_done == 0 && k < 3) begin
      @(negedge clk); k++;
    end
    chk(n_done == 1, "R7 zero count done", n_done, 1);
    repeat (4) @(negedge clk);
    chk(n_rd == 0 && n_wr == 0 && !bus_req, "R7 zero count no bus", n_rd + n_wr, 0);
  endtask

  task automatic t_grant_delay;
    dreq_n = 1'b0;
    gnt_en = 1'b0;
    launch(1'b0, 1'b0, 2'd1, 1, 32'h700, 32'h0);
    repeat (8) @(negedge clk);
    chk(bus_req == 1'b1, "R9 request pending", bus_req, 1);
    chk(n_rd == 0 && n_wr == 0, "R9 no strobe before grant", n_rd + n_wr, 0);
    @(posedge clk); #1; gnt_en = 1'b1;
    wait_done("R9 grant done");
    chk(n_rd == 1 && rd_log[0] == 32'h700, "R9 R6 unit after grant", rd_log[0], 32'h700);
  endtask

  task automatic t_no_request;
    dreq_n = 1'b1;
    launch(1'b1, 1'b0, 2'd3, 2, 32'h800, 32'h0);
    repeat (8) @(negedge clk);
    chk(!bus_req && n_rd == 0, "R9 idle without request", bus_req, 0);
    @(posedge clk); #1; dreq_n = 1'b0;
    wait_done("R9 request done");
    chk_addrs("R8 size3 steps 4", 2, 32'h800, step_of(2'd3), 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset();
    t_cycle_steal_dual();
    t_burst_dual();
    t_burst_single();
    t_burst_early();
    t_zero_count();
    t_grant_delay();
    t_no_request();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule